// File: doc/BRIEF.md
# Packed Rounded-Average and Byte SAD Unit

This block is a pipelined 64-bit SIMD datapath that performs one of three operations on two packed operands, picked by a 2-bit opcode. Two operations form rounded unsigned averages lane by lane, on eight byte lanes or on four 16-bit lanes. The third forms the absolute difference of each of the eight byte pairs, reading each byte as a signed value. It then reduces the eight magnitudes to one unsigned 16-bit total.

The byte magnitudes pass through an adder tree that is split by registers. Because of this, every opcode has the same three-cycle latency. A new operation can enter on every clock. The valid flag travels with the data. It is used as a fixed-latency execution slot inside a media pipeline.

Top module: `simd_avgsad_unit`

## Requirements
- R1: With opcode 0, result byte i (bits 8i+7..8i) equals (a_i + b_i + 1) >> 1, where a_i and b_i are the unsigned bytes of in_a and in_b at that position and the sum is kept one bit wider than the lane (so FFh with FFh gives FFh).
- R2: With opcode 1, result 16-bit lane j (bits 16j+15..16j) equals (a_j + b_j + 1) >> 1 on unsigned 16-bit values, with a 17-bit sum.
- R3: With opcode 2, bits 15..0 of the result hold the unsigned sum over the eight byte positions of |a_i - b_i|, where each byte is read as an 8-bit two's-complement value (01h versus FFh gives 2).
- R4: With opcode 2, result bits 63..16 are all zero.
- R5: Opcode 3 is reserved and yields an all-zero result with out_valid still set.
- R6: out_valid is asserted exactly three clock edges after in_valid is sampled high, carrying that operation's result. Operations issued on consecutive cycles come out on consecutive cycles.
- R7: A synchronous reset (rst high at a clock edge) clears every pipeline stage, so out_valid and out_data are zero after that edge and stay zero for the following two edges. Operations that are in flight are dropped.
- R8: Whenever out_valid is low, out_data is zero.
- R9: The largest SAD, eight lanes of 7Fh against 80h, gives 07F8h (2040) with no wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation present on the inputs this cycle |
| in_op | input | 2 | 0 byte average, 1 word average, 2 byte SAD, 3 reserved |
| in_a | input | 64 | First packed operand |
| in_b | input | 64 | Second packed operand |
| out_valid | output | 1 | Result valid, three cycles after in_valid |
| out_data | output | 64 | Packed result |

## Verification
The hardest situations to reach from the ports are the ones that only a few input values produce. One is the carry out of a lane sum. Another is the SAD extreme, where every signed byte difference has magnitude 255. A third is where signed and unsigned readings of the bytes give different magnitudes. Random operands rarely hit all lanes at once, so directed vectors drive saturated bytes and words, 7Fh against 80h in every lane, and 01h against FFh. A reset asserted while valid operations are still in the pipeline checks that nothing in flight comes out afterwards.

// File: rtl/simd_avgsad_pkg.sv
package simd_avgsad_pkg;

    typedef enum logic [1:0] {
        OP_AVG_B = 2'd0,
        OP_AVG_W = 2'd1,
        OP_SAD   = 2'd2,
        OP_RSVD  = 2'd3
    } simd_op_e;

endpackage

// File: rtl/simd_lane_avg.sv
module simd_lane_avg #(
    parameter int LANE_W = 8,
    parameter int LANES  = 8
) (
    input  logic [LANE_W*LANES-1:0] op_a,
    input  logic [LANE_W*LANES-1:0] op_b,
    output logic [LANE_W*LANES-1:0] avg
);
    localparam int SUM_W = LANE_W + 1;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [SUM_W-1:0] wide_sum;
        assign wide_sum = {1'b0, op_a[g*LANE_W +: LANE_W]}
                        + {1'b0, op_b[g*LANE_W +: LANE_W]}
                        + SUM_W'(1);
        assign avg[g*LANE_W +: LANE_W] = wide_sum[SUM_W-1:1];
    end

endmodule

// File: rtl/simd_absdiff.sv
module simd_absdiff #(
    parameter int ELEM_W = 8,
    parameter int LANES  = 8
) (
    input  logic [ELEM_W*LANES-1:0] op_a,
    input  logic [ELEM_W*LANES-1:0] op_b,
    output logic [ELEM_W*LANES-1:0] mag
);
    localparam int DIFF_W = ELEM_W + 1;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [ELEM_W-1:0] ea;
        logic [ELEM_W-1:0] eb;
        logic [DIFF_W-1:0] diff;
        logic [DIFF_W-1:0] pos;
        assign ea   = op_a[g*ELEM_W +: ELEM_W];
        assign eb   = op_b[g*ELEM_W +: ELEM_W];
        // sign-extended subtraction, range -(2^ELEM_W - 1) .. +(2^ELEM_W - 1)
        assign diff = {ea[ELEM_W-1], ea} - {eb[ELEM_W-1], eb};
        assign pos  = diff[DIFF_W-1] ? (~diff + DIFF_W'(1)) : diff;
        assign mag[g*ELEM_W +: ELEM_W] = pos[ELEM_W-1:0];
    end

endmodule

// File: rtl/simd_reduce_add.sv
module simd_reduce_add #(
    parameter int IN_W  = 8,
    parameter int N     = 4,
    parameter int OUT_W = 16
) (
    input  logic [IN_W*N-1:0] terms,
    output logic [OUT_W-1:0]  total
);
    always_comb begin
        total = '0;
        for (int i = 0; i < N; i++) begin
            total = total + OUT_W'(terms[i*IN_W +: IN_W]);
        end
    end

endmodule

// File: rtl/simd_avgsad_unit.sv
module simd_avgsad_unit
    import simd_avgsad_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int SAD_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        in_op,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;
    localparam int NB     = DATA_W / BYTE_W;
    localparam int NW     = DATA_W / WORD_W;
    localparam int HALF   = NB / 2;
    localparam int HALF_W = HALF * BYTE_W;

    typedef struct packed {
        // stage 1: lane results and byte magnitudes
        logic              s1_vld;
        simd_op_e          s1_op;
        logic [DATA_W-1:0] s1_avg;
        logic [DATA_W-1:0] s1_mag;
        // stage 2: two partial SAD sums
        logic              s2_vld;
        simd_op_e          s2_op;
        logic [DATA_W-1:0] s2_avg;
        logic [SAD_W-1:0]  s2_lo;
        logic [SAD_W-1:0]  s2_hi;
        // stage 3: formatted result
        logic              s3_vld;
        logic [DATA_W-1:0] s3_data;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic [DATA_W-1:0] avg_b, avg_w, mag;
    logic [SAD_W-1:0]  part_lo, part_hi;

    simd_lane_avg #(.LANE_W(BYTE_W), .LANES(NB)) u_avg_b (
        .op_a(in_a), .op_b(in_b), .avg(avg_b)
    );

    simd_lane_avg #(.LANE_W(WORD_W), .LANES(NW)) u_avg_w (
        .op_a(in_a), .op_b(in_b), .avg(avg_w)
    );

    simd_absdiff #(.ELEM_W(BYTE_W), .LANES(NB)) u_absdiff (
        .op_a(in_a), .op_b(in_b), .mag(mag)
    );

    simd_reduce_add #(.IN_W(BYTE_W), .N(HALF), .OUT_W(SAD_W)) u_red_lo (
        .terms(pipe_q.s1_mag[HALF_W-1:0]), .total(part_lo)
    );

    simd_reduce_add #(.IN_W(BYTE_W), .N(NB - HALF), .OUT_W(SAD_W)) u_red_hi (
        .terms(pipe_q.s1_mag[DATA_W-1:HALF_W]), .total(part_hi)
    );

    always_comb begin
        pipe_d = pipe_q;

        pipe_d.s1_vld = in_valid;
        pipe_d.s1_op  = simd_op_e'(in_op);
        pipe_d.s1_avg = (simd_op_e'(in_op) == OP_AVG_W) ? avg_w : avg_b;
        pipe_d.s1_mag = mag;

        pipe_d.s2_vld = pipe_q.s1_vld;
        pipe_d.s2_op  = pipe_q.s1_op;
        pipe_d.s2_avg = pipe_q.s1_avg;
        pipe_d.s2_lo  = part_lo;
        pipe_d.s2_hi  = part_hi;

        pipe_d.s3_vld  = pipe_q.s2_vld;
        pipe_d.s3_data = '0;
        if (pipe_q.s2_vld) begin
            case (pipe_q.s2_op)
                OP_AVG_B, OP_AVG_W: pipe_d.s3_data = pipe_q.s2_avg;
                OP_SAD:   pipe_d.s3_data[SAD_W-1:0] = pipe_q.s2_lo + pipe_q.s2_hi;
                default:  pipe_d.s3_data = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign out_valid = pipe_q.s3_vld;
    assign out_data  = pipe_q.s3_data;

endmodule

// File: rtl/simd_avgsad_checker.sv
module simd_avgsad_checker #(
    parameter int DATA_W = 64,
    parameter int SAD_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [1:0]        in_op,
    input logic [DATA_W-1:0] in_a,
    input logic [DATA_W-1:0] in_b,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data
);
    localparam int NB      = DATA_W / 8;
    localparam int SAD_MAX = NB * 255;

    // edges seen since reset, saturating at the pipeline depth
    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (rst) warm <= '0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    p_latency_r6: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    p_sad_upper_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd3 && $past(in_valid, 3) && $past(in_op, 3) == 2'd2)
        |-> (out_data[DATA_W-1:SAD_W] == '0));

    p_sad_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd3 && $past(in_valid, 3) && $past(in_op, 3) == 2'd2)
        |-> (out_data[SAD_W-1:0] <= SAD_W'(SAD_MAX)));

    p_rsvd_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd3 && $past(in_valid, 3) && $past(in_op, 3) == 2'd3)
        |-> (out_data == '0));

    p_avg_lane0_r1: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd3 && $past(in_valid, 3) && $past(in_op, 3) == 2'd0)
        |-> (out_data[7:0] ==
             8'((9'($past(in_a[7:0], 3)) + 9'($past(in_b[7:0], 3)) + 9'd1) >> 1)));

    p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_data == '0));

    p_reset_clear_r7: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0));

endmodule

bind simd_avgsad_unit simd_avgsad_checker #(.DATA_W(DATA_W), .SAD_W(SAD_W)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_data(out_data)
);

// File: tb/tb_simd_avgsad_unit.sv
module tb_simd_avgsad_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  in_op = 2'd0;
    logic [63:0] in_a = '0;
    logic [63:0] in_b = '0;
    logic        out_valid;
    logic [63:0] out_data;

    int checks = 0;
    int fails  = 0;

    logic        hv [3];
    logic [63:0] hd [3];
    string       ht [3];

    always #4 clk = ~clk;   // 125 MHz

    simd_avgsad_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [63:0] model(logic [1:0] op, logic [63:0] a, logic [63:0] b);
        logic [63:0] r;
        int s;
        r = '0;
        s = 0;
        case (op)
            2'd0: for (int i = 0; i < 8; i++)
                      r[8*i +: 8] = 8'((int'(a[8*i +: 8]) + int'(b[8*i +: 8]) + 1) >> 1);
            2'd1: for (int j = 0; j < 4; j++)
                      r[16*j +: 16] = 16'((int'(a[16*j +: 16]) + int'(b[16*j +: 16]) + 1) >> 1);
            2'd2: begin
                for (int i = 0; i < 8; i++) begin
                    int d;
                    d = int'($signed(a[8*i +: 8])) - int'($signed(b[8*i +: 8]));
                    s += (d < 0) ? -d : d;
                end
                r[15:0] = 16'(s);
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic string op_tag(logic [1:0] op);
        case (op)
            2'd0: return "R1";
            2'd1: return "R2";
            2'd2: return "R3";
            default: return "R5";
        endcase
    endfunction

    task automatic check(string tag, logic v_act, logic [63:0] d_act, logic v_exp, logic [63:0] d_exp);
        checks++;
        if (v_act !== v_exp || d_act !== d_exp) begin
            fails++;
            $display("FAIL %s: actual valid=%0b data=%016h expected valid=%0b data=%016h",
                     tag, v_act, d_act, v_exp, d_exp);
        end
    endtask

    // one cycle: check the entry issued three cycles ago, then drive new inputs
    task automatic step(logic r, logic v, logic [1:0] op, logic [63:0] a, logic [63:0] b, string tag);
        @(negedge clk);
        check(ht[2], out_valid, out_data, hv[2], hd[2]);
        if (hv[2] && ht[2] == "R3") begin
            checks++;
            if (out_data[63:16] !== '0) begin
                fails++;
                $display("FAIL R4: actual upper=%012h expected upper=000000000000", out_data[63:16]);
            end
        end
        hv[2] = hv[1]; hd[2] = hd[1]; ht[2] = ht[1];
        hv[1] = hv[0]; hd[1] = hd[0]; ht[1] = ht[0];
        if (r) begin
            for (int k = 0; k < 3; k++) begin
                hv[k] = 1'b0; hd[k] = '0; ht[k] = "R7";
            end
        end else if (v) begin
            hv[0] = 1'b1; hd[0] = model(op, a, b); ht[0] = (tag == "") ? op_tag(op) : tag;
        end else begin
            hv[0] = 1'b0; hd[0] = '0; ht[0] = "R8";
        end
        rst = r; in_valid = v; in_op = op; in_a = a; in_b = b;
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [63:0] ra, rb;
        int seed;
        seed = 32'h5ad1;
        void'($urandom(seed));
        for (int k = 0; k < 3; k++) begin
            hv[k] = 1'b0; hd[k] = '0; ht[k] = "R7";
        end
        // reset state (R7)
        for (int k = 0; k < 4; k++) step(1'b1, 1'b0, 2'd0, '0, '0, "R7");

        // R1 directed: carry kept, round-half-up, zero
        step(1'b0, 1'b1, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "R1");
        step(1'b0, 1'b1, 2'd0, 64'hFF00_FF00_0100_FE01, 64'h0000_0001_0000_FF02, "R1");
        // R2 directed
        step(1'b0, 1'b1, 2'd1, 64'hFFFF_FFFF_0000_8000, 64'hFFFF_0000_0001_7FFF, "R2");
        // R3 signed interpretation: 01 vs FF gives 2 per lane
        step(1'b0, 1'b1, 2'd2, 64'h0101_0101_0101_0101, 64'hFFFF_FFFF_FFFF_FFFF, "R3");
        step(1'b0, 1'b1, 2'd2, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, "R3");
        // R9 extreme SAD
        step(1'b0, 1'b1, 2'd2, 64'h7F7F_7F7F_7F7F_7F7F, 64'h8080_8080_8080_8080, "R9");
        step(1'b0, 1'b1, 2'd2, 64'h8080_8080_8080_8080, 64'h7F7F_7F7F_7F7F_7F7F, "R9");
        // R5 reserved opcode
        step(1'b0, 1'b1, 2'd3, 64'hDEAD_BEEF_0123_4567, 64'h0F0F_F0F0_AAAA_5555, "R5");
        // R6 back-to-back with a gap
        step(1'b0, 1'b1, 2'd1, 64'h0001_0002_0003_0004, 64'h0005_0006_0007_0008, "R6");
        step(1'b0, 1'b0, 2'd2, 64'h1111_1111_1111_1111, 64'h2222_2222_2222_2222, "");
        step(1'b0, 1'b1, 2'd0, 64'h0102_0304_0506_0708, 64'h0807_0605_0403_0201, "R6");
        // R7 mid-flight reset drops in-flight work
        step(1'b0, 1'b1, 2'd2, 64'h7F7F_7F7F_7F7F_7F7F, 64'h8080_8080_8080_8080, "R7");
        step(1'b0, 1'b1, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, "R7");
        step(1'b1, 1'b1, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "R7");
        for (int k = 0; k < 3; k++) step(1'b0, 1'b0, 2'd0, '0, '0, "");

        // constrained random, mostly valid, all opcodes
        for (int n = 0; n < 400; n++) begin
            logic v;
            logic [1:0] op;
            ra = {$urandom(), $urandom()};
            rb = {$urandom(), $urandom()};
            if (($urandom() % 4) == 0) rb = ra ^ 64'(($urandom() % 256));
            v  = (($urandom() % 8) != 0);
            op = 2'(($urandom() % 16) < 1 ? 3 : ($urandom() % 3));
            step(1'b0, v, op, ra, rb, "");
        end
        for (int k = 0; k < 3; k++) step(1'b0, 1'b0, 2'd0, '0, '0, "");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule